// File: doc/BRIEF.md
# Processor Presence and Hotplug Event Registers

This block keeps a one-bit-per-processor presence map for up to `MAX_CPUS` processors and exposes it as a window of bytes on a byte-wide I/O bus. Processor `n` is held in map byte `n/8`, bit `n%8`. After reset the map shows the processors brought up at boot. The lowest `BOOT_CPUS` bits are set and every bit above them is clear.

A hotplug request carries a processor index and an add/remove flag. It sets or clears that processor's presence bit and latches the processor event flag in a small event status register. A separate input latches the PCI hotplug event flag in the same register. Software reads the status register and clears its flags by writing ones. An enable register selects which flags may raise the level-sensitive system control interrupt.

The interrupt line comes from a two-state machine. `SCI_IDLE` moves to `SCI_ACTIVE` on transition RAISE, when an enabled event flag is pending. `SCI_ACTIVE` returns to `SCI_IDLE` on transition DROP, when no enabled flag remains pending.

Top module: `cpuhp_evt_regs`

## Requirements
- R1: After reset, presence bit n reads 1 for n < BOOT_CPUS and 0 otherwise. With BOOT_CPUS=11, map bytes 0, 1 and 2 read 0xFF, 0x07 and 0x00.
- R2: A read at MAP_BASE+k (default 0xAF00) returns map byte k. Processor n appears in byte n/8 at bit n%8.
- R3: A hotplug request with add=1 sets the processor's presence bit, and one with add=0 clears it. Either kind sets status bit 2 (mask 0x04) one clock later.
- R4: A PCI hotplug event pulse sets status bit 1 (mask 0x02).
- R5: Writing to a status byte clears each bit written as 1 and leaves each bit written as 0 unchanged. Only bits 1 and 2 can ever become set.
- R6: In the event window at EVT_BASE (default 0xAFE0), offsets 0 and 1 hold the low and high status bytes. Offsets 2 and 3 hold the low and high enable bytes, which are plain read/write.
- R7: The interrupt line is high exactly when (status AND enable) has bit 1 or bit 2 set. It follows a change of status or enable one clock later.
- R8: Writes into the map window have no effect, and reads outside both windows return 0x00.
- R9: When a hotplug request and a write clearing status bit 2 happen in the same cycle, bit 2 ends set.
- R10: After reset, status and enable read 0x00 and the interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | I/O byte address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, combinational from bus_addr |
| hp_req | input | 1 | Hotplug request strobe |
| hp_add | input | 1 | 1 = add processor, 0 = remove |
| hp_idx | input | IDX_W | Processor index |
| pci_evt | input | 1 | PCI hotplug event pulse |
| sci | output | 1 | Level system control interrupt |

## Verification
The bench builds the block with MAX_CPUS=256, which gives a full 32-byte window, and BOOT_CPUS=11. The boot count leaves a partial byte after one full byte, so the reset fill is checked on a whole byte, a partial byte and an empty byte. The highest index, 255, reaches the last byte of the window. It is used in the case where a hotplug request and a clearing write land in the same cycle.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;
    localparam int EVT_BYTES   = 4;
    localparam int STS_PCI_BIT = 1;
    localparam int STS_CPU_BIT = 2;

    typedef enum logic {
        SCI_IDLE   = 1'b0,
        SCI_ACTIVE = 1'b1
    } sci_state_e;
endpackage

// File: rtl/cpuhp_presence_map.sv
module cpuhp_presence_map #(
    parameter int MAX_CPUS  = 256,
    parameter int BOOT_CPUS = 1,
    parameter int IDX_W     = $clog2(MAX_CPUS),
    parameter int MAP_AW    = $clog2(MAX_CPUS / 8)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hp_req,
    input  logic                hp_add,
    input  logic [IDX_W-1:0]    hp_idx,
    input  logic [MAP_AW-1:0]   rd_byte,
    output logic [7:0]          rd_data,
    output logic [MAX_CPUS-1:0] map_q
);
    for (genvar n = 0; n < MAX_CPUS; n++) begin : g_bit
        localparam logic BOOT_VAL = (n < BOOT_CPUS) ? 1'b1 : 1'b0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                map_q[n] <= BOOT_VAL;
            end else if (hp_req && (hp_idx == IDX_W'(n))) begin
                map_q[n] <= hp_add;
            end
        end
    end

    always_comb begin
        rd_data = map_q[rd_byte*8 +: 8];
    end
endmodule

// File: rtl/cpuhp_gpe_block.sv
module cpuhp_gpe_block
    import cpuhp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  off,
    input  logic [7:0]  wdata,
    input  logic        cpu_evt,
    input  logic        pci_evt,
    output logic [15:0] sts_q,
    output logic [15:0] en_q,
    output logic [7:0]  rd_data
);
    logic [15:0] clr_mask;
    logic [15:0] set_mask;
    logic [15:0] sts_d;

    always_comb begin
        clr_mask = '0;
        if (wr_en && off == 2'd0) clr_mask[7:0]  = wdata;
        if (wr_en && off == 2'd1) clr_mask[15:8] = wdata;
        set_mask = '0;
        set_mask[STS_CPU_BIT] = cpu_evt;
        set_mask[STS_PCI_BIT] = pci_evt;
        // set wins over a same-cycle clear so no event is lost
        sts_d = (sts_q & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
            en_q  <= '0;
        end else begin
            sts_q <= sts_d;
            if (wr_en && off == 2'd2) en_q[7:0]  <= wdata;
            if (wr_en && off == 2'd3) en_q[15:8] <= wdata;
        end
    end

    always_comb begin
        unique case (off)
            2'd0: rd_data = sts_q[7:0];
            2'd1: rd_data = sts_q[15:8];
            2'd2: rd_data = en_q[7:0];
            2'd3: rd_data = en_q[15:8];
        endcase
    end
endmodule

// File: rtl/cpuhp_sci_fsm.sv
module cpuhp_sci_fsm
    import cpuhp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] sts,
    input  logic [15:0] en,
    output logic        sci
);
    sci_state_e state_q, state_d;
    logic       pending;

    always_comb begin
        pending = (sts[STS_CPU_BIT] & en[STS_CPU_BIT]) |
                  (sts[STS_PCI_BIT] & en[STS_PCI_BIT]);
        state_d = state_q;
        unique case (state_q)
            SCI_IDLE:   if (pending)  state_d = SCI_ACTIVE; // RAISE
            SCI_ACTIVE: if (!pending) state_d = SCI_IDLE;   // DROP
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SCI_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        sci = (state_q == SCI_ACTIVE);
    end
endmodule

// File: rtl/cpuhp_evt_regs.sv
module cpuhp_evt_regs
    import cpuhp_pkg::*;
#(
    parameter int              MAX_CPUS  = 256,
    parameter int              BOOT_CPUS = 1,
    parameter int              ADDR_W    = 16,
    parameter logic [15:0]     MAP_BASE  = 16'hAF00,
    parameter logic [15:0]     EVT_BASE  = 16'hAFE0,
    localparam int             IDX_W     = $clog2(MAX_CPUS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              hp_req,
    input  logic              hp_add,
    input  logic [IDX_W-1:0]  hp_idx,
    input  logic              pci_evt,
    output logic              sci
);
    localparam int              MAP_BYTES = MAX_CPUS / 8;
    localparam int              MAP_AW    = $clog2(MAP_BYTES);
    localparam logic [ADDR_W-1:0] MAP_LO  = ADDR_W'(MAP_BASE);
    localparam logic [ADDR_W-1:0] EVT_LO  = ADDR_W'(EVT_BASE);
    localparam logic [ADDR_W-1:0] MAP_SPAN = ADDR_W'(MAP_BYTES);
    localparam logic [ADDR_W-1:0] EVT_SPAN = ADDR_W'(EVT_BYTES);

    logic [ADDR_W-1:0]   map_off, evt_off;
    logic                in_map, in_evt;
    logic [7:0]          map_rd, evt_rd;
    logic [MAX_CPUS-1:0] map_q;
    logic [15:0]         sts_q, en_q;

    always_comb begin
        map_off = bus_addr - MAP_LO;
        evt_off = bus_addr - EVT_LO;
        in_map  = (bus_addr >= MAP_LO) && (map_off < MAP_SPAN);
        in_evt  = (bus_addr >= EVT_LO) && (evt_off < EVT_SPAN);
        if (in_map)      bus_rdata = map_rd;
        else if (in_evt) bus_rdata = evt_rd;
        else             bus_rdata = 8'h00;
    end

    cpuhp_presence_map #(
        .MAX_CPUS (MAX_CPUS),
        .BOOT_CPUS(BOOT_CPUS),
        .IDX_W    (IDX_W),
        .MAP_AW   (MAP_AW)
    ) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .hp_req (hp_req),
        .hp_add (hp_add),
        .hp_idx (hp_idx),
        .rd_byte(map_off[MAP_AW-1:0]),
        .rd_data(map_rd),
        .map_q  (map_q)
    );

    cpuhp_gpe_block u_gpe (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr && in_evt),
        .off    (evt_off[1:0]),
        .wdata  (bus_wdata),
        .cpu_evt(hp_req),
        .pci_evt(pci_evt),
        .sts_q  (sts_q),
        .en_q   (en_q),
        .rd_data(evt_rd)
    );

    cpuhp_sci_fsm u_sci (
        .clk  (clk),
        .rst_n(rst_n),
        .sts  (sts_q),
        .en   (en_q),
        .sci  (sci)
    );
endmodule

// File: rtl/cpuhp_evt_regs_chk.sv
module cpuhp_evt_regs_chk #(
    parameter int          MAX_CPUS = 256,
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] MAP_BASE = 16'hAF00,
    parameter logic [15:0] EVT_BASE = 16'hAFE0,
    localparam int         IDX_W    = $clog2(MAX_CPUS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [7:0]          bus_wdata,
    input logic [7:0]          bus_rdata,
    input logic                hp_req,
    input logic                hp_add,
    input logic [IDX_W-1:0]    hp_idx,
    input logic                pci_evt,
    input logic                sci,
    input logic [MAX_CPUS-1:0] map_q,
    input logic [15:0]         sts_q,
    input logic [15:0]         en_q
);
    logic hit;
    logic outside;
    always_comb begin
        hit = |(sts_q[2:1] & en_q[2:1]);
        outside = (int'(bus_addr) < int'(MAP_BASE)) ||
                  ((int'(bus_addr) >= int'(MAP_BASE) + MAX_CPUS / 8) &&
                   (int'(bus_addr) < int'(EVT_BASE))) ||
                  (int'(bus_addr) >= int'(EVT_BASE) + 4);
    end

    assert_add_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hp_req && hp_add |=> map_q[$past(hp_idx)]);
    assert_rm_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hp_req && !hp_add |=> !map_q[$past(hp_idx)]);
    assert_cpu_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hp_req |=> sts_q[2]);
    assert_pci_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pci_evt |=> sts_q[1]);
    assert_enable_rw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (bus_addr == ADDR_W'(EVT_BASE) + ADDR_W'(2)) |=> en_q[7:0] == $past(bus_wdata));
    assert_sci_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sci == $past(hit));
    assert_map_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hp_req |=> $stable(map_q));
    assert_outside_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        outside |-> bus_rdata == 8'h00);
endmodule

bind cpuhp_evt_regs cpuhp_evt_regs_chk #(
    .MAX_CPUS(MAX_CPUS),
    .ADDR_W  (ADDR_W),
    .MAP_BASE(MAP_BASE),
    .EVT_BASE(EVT_BASE)
) u_chk (.*);

// File: tb/cpuhp_evt_regs_tb.sv
module cpuhp_evt_regs_tb;
    localparam int MAX_CPUS  = 256;
    localparam int BOOT_CPUS = 11;

    typedef struct {
        bit         sel;
        logic [7:0] exp;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        hp_req = 1'b0;
    logic        hp_add = 1'b0;
    logic [7:0]  hp_idx = '0;
    logic        pci_evt = 1'b0;
    logic        sci;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    cpuhp_evt_regs #(.MAX_CPUS(MAX_CPUS), .BOOT_CPUS(BOOT_CPUS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hp_req(hp_req),
        .hp_add(hp_add), .hp_idx(hp_idx), .pci_evt(pci_evt), .sci(sci)
    );

    // monitor: pops expected items and compares away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t it;
                logic [7:0] act;
                it  = q.pop_front();
                act = it.sel ? {7'b0, sci} : bus_rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic hp(input logic [7:0] i, input logic add);
        hp_idx = i; hp_add = add; hp_req = 1'b1;
        step();
        hp_req = 1'b0;
    endtask

    task automatic pci();
        pci_evt = 1'b1;
        step();
        pci_evt = 1'b0;
    endtask

    task automatic chk_rd(input logic [15:0] a, input logic [7:0] e, input string tag);
        bus_addr = a;
        q.push_back('{1'b0, e, tag});
        step();
    endtask

    task automatic chk_sci(input logic e, input string tag);
        step();
        q.push_back('{1'b1, {7'b0, e}, tag});
        step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        // R1 / R10 reset state
        chk_rd(16'hAF00, 8'hFF, "R1 byte0");
        chk_rd(16'hAF01, 8'h07, "R1 byte1");
        chk_rd(16'hAF02, 8'h00, "R1 byte2");
        chk_rd(16'hAF1F, 8'h00, "R1 byte31");
        chk_rd(16'hAFE0, 8'h00, "R10 status");
        chk_rd(16'hAFE2, 8'h00, "R10 enable");
        chk_sci(1'b0, "R10 sci");
        // R8 map writes ignored, outside reads zero
        wr(16'hAF00, 8'h00);
        chk_rd(16'hAF00, 8'hFF, "R8 map write ignored");
        chk_rd(16'hAF20, 8'h00, "R8 gap read");
        chk_rd(16'h1234, 8'h00, "R8 far read");
        chk_rd(16'hAFE4, 8'h00, "R8 past event window");
        // R2 / R3 add processor 12
        hp(8'd12, 1'b1);
        chk_rd(16'hAF01, 8'h17, "R2 add 12 byte1");
        chk_rd(16'hAFE0, 8'h04, "R3 cpu flag");
        chk_sci(1'b0, "R7 masked by enable");
        // R6 / R7 enable
        wr(16'hAFE2, 8'h06);
        chk_rd(16'hAFE2, 8'h06, "R6 enable low");
        chk_sci(1'b1, "R7 raise");
        // R5 write-one-to-clear
        wr(16'hAFE0, 8'h00);
        chk_rd(16'hAFE0, 8'h04, "R5 zero write keeps");
        wr(16'hAFE0, 8'h04);
        chk_rd(16'hAFE0, 8'h00, "R5 one clears");
        chk_sci(1'b0, "R7 drop");
        // R3 remove processor 0
        hp(8'd0, 1'b0);
        chk_rd(16'hAF00, 8'hFE, "R3 remove 0");
        chk_sci(1'b1, "R7 after remove");
        wr(16'hAFE0, 8'h04);
        // R4 PCI event
        pci();
        chk_rd(16'hAFE0, 8'h02, "R4 pci flag");
        chk_sci(1'b1, "R7 pci raise");
        wr(16'hAFE2, 8'h04);
        chk_sci(1'b0, "R7 pci masked");
        wr(16'hAFE0, 8'h02);
        chk_rd(16'hAFE0, 8'h00, "R5 clear pci");
        // R9 same-cycle set and clear
        bus_addr = 16'hAFE0; bus_wdata = 8'h04; bus_wr = 1'b1;
        hp_idx = 8'd255; hp_add = 1'b1; hp_req = 1'b1;
        step();
        bus_wr = 1'b0; hp_req = 1'b0;
        chk_rd(16'hAFE0, 8'h04, "R9 set wins");
        chk_rd(16'hAF1F, 8'h80, "R2 add 255 byte31");
        // R6 high bytes
        wr(16'hAFE3, 8'hA5);
        chk_rd(16'hAFE3, 8'hA5, "R6 enable high");
        wr(16'hAFE1, 8'hFF);
        chk_rd(16'hAFE1, 8'h00, "R5 status high stays zero");
        step();
        step();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule